// File: doc/BRIEF.md
# Read Completion Packet Splitter

This block sits between a memory-mapped slave that answers reads and the transaction layer that sends completions back to the requester. It takes one read request at a time (tag, requester ID, starting byte address and a length in 32-bit dwords). It then forwards the slave's response data as a sequence of completion packets. No packet is longer than the maximum payload, which is chosen at run time by a 2-bit select.

Every output beat carries a header sideband that stays constant for the whole packet. The sideband holds the requester's tag and ID, the byte count still owed for the request (including this packet), the low seven bits of the byte address of the packet's first dword, and the packet length in dwords. Data moves through with no storage. A beat is passed on only when the slave offers data and the transaction layer can take it, so packets leave in request order and a request's packets never interleave with another's. The next request is taken only after the final beat of the current one has been handed off.

Top module: `read_cpl_splitter`

## Requirements
- R1: Out of reset and after any reset, `req_ready` is 1 while `cpl_valid` and `rd_ready` are 0, even when `rd_valid` is 1.
- R2: While a request is in progress, `req_ready` is 0 and a raised `req_valid` has no effect: the tag, requester ID and packet sequence of the current request continue unchanged.
- R3: The payload limit is decoded from `mps_sel` as 0 → 32 dwords, 1 → 64, 2 → 128 and 3 → 32. It is sampled when a request is accepted, and later changes of `mps_sel` do not affect that request.
- R4: Each packet is min(remaining dwords, limit) long, so only the last packet can be short. A 128-dword (512-byte) read with a 32-dword (128-byte) limit gives four 32-dword packets.
- R5: `cpl_bytecount` equals 4 × (dwords of the request not yet sent before this packet), held for the whole packet.
- R6: `cpl_lowaddr` equals bits [6:0] of (start address + 4 × dwords sent before this packet).
- R7: `cpl_sop` is 1 on the first beat of each packet and `cpl_eop` is 1 on its last beat. A one-dword packet has both set.
- R8: `cpl_valid` is `rd_valid` gated by an active request, `rd_ready` is `cpl_ready` gated by an active request, and `cpl_data` carries the slave data beat for beat in arrival order.
- R9: A `req_len_dw` of 0 means 1024 dwords.
- R10: `req_ready` returns to 1 in the cycle after the handshake of the last beat of a request, and not before. No beat is presented while idle.
- R11: While `cpl_valid` is 1 and `cpl_ready` is 0, all header sideband fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mps_sel | input | 2 | Payload limit select (0:32, 1:64, 2:128, 3:32 dwords) |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_tag | input | 8 | Requester tag |
| req_rid | input | 16 | Requester ID |
| req_addr | input | 32 | Starting byte address (dword aligned) |
| req_len_dw | input | 10 | Length in dwords, 0 means 1024 |
| rd_valid | input | 1 | Slave response data valid |
| rd_ready | output | 1 | Response data taken |
| rd_data | input | 32 | Slave response data |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_ready | input | 1 | Transaction layer accepts beat |
| cpl_data | output | 32 | Completion payload dword |
| cpl_sop | output | 1 | First beat of a packet |
| cpl_eop | output | 1 | Last beat of a packet |
| cpl_tag | output | 8 | Tag of the request being served |
| cpl_rid | output | 16 | Requester ID of the request being served |
| cpl_bytecount | output | 13 | Bytes remaining including this packet |
| cpl_lowaddr | output | 7 | Low address bits of packet's first byte |
| cpl_len_dw | output | 11 | Packet length in dwords |

## Verification
The splitting path is run with lengths that are exact multiples of the limit, lengths that leave a short last packet, a single dword, and the 1024-dword encoding. These runs separate a correct min(remaining, limit) from off-by-one packet boundaries and a wrong remainder. Each limit select, including the reserved code, is tried, and one run changes `mps_sel` in mid-request to show that the limit was sampled at acceptance. Back-pressure on `cpl_ready` and gaps in `rd_valid` are applied separately and together, to show that beat counting and header stepping advance only on a handshake. A request raised while busy and a reset in mid-packet show that neither the current request nor the idle state can be disturbed.

// File: rtl/rcs_pkg.sv
// Package rcs_pkg: shared encodings for the read completion splitter.
// Assumes payload limits are expressed in 32-bit dwords.
package rcs_pkg;
    typedef enum logic [1:0] {
        MPS_B128  = 2'd0,
        MPS_B256  = 2'd1,
        MPS_B512  = 2'd2,
        MPS_RSVD  = 2'd3
    } mps_code_e;
endpackage

// File: rtl/rcs_mps_decode.sv
// Module rcs_mps_decode: turns the 2-bit payload select into a dword limit.
// Assumes the reserved code falls back to the smallest limit.
module rcs_mps_decode #(
    parameter int REM_W = 11
) (
    input  logic [1:0]       sel,
    output logic [REM_W-1:0] max_dw
);
    import rcs_pkg::*;

    // Map each select code onto its dword limit.
    always_comb begin
        unique case (mps_code_e'(sel))
            MPS_B256: max_dw = REM_W'(64);
            MPS_B512: max_dw = REM_W'(128);
            default:  max_dw = REM_W'(32);
        endcase
    end
endmodule

// File: rtl/rcs_req_tracker.sv
// Module rcs_req_tracker: holds the request being served, the dwords still
// owed, the address of the next packet and the sampled payload limit.
// Assumes pkt_fire pulses once per finished packet with that packet's length.
module rcs_req_tracker #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 8,
    parameter int RID_W  = 16,
    parameter int LEN_W  = 10,
    localparam int REM_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [RID_W-1:0]  in_rid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [REM_W-1:0]  in_max_dw,
    input  logic              pkt_fire,
    input  logic [REM_W-1:0]  pkt_len,
    output logic              busy,
    output logic [TAG_W-1:0]  tag_q,
    output logic [RID_W-1:0]  rid_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [REM_W-1:0]  rem_q,
    output logic [REM_W-1:0]  max_q
);
    logic [REM_W-1:0] len_full;

    // A zero length field stands for the largest transfer.
    always_comb begin
        len_full = (in_len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, in_len};
    end

    // Load on acceptance, step remainder and address after each packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tag_q  <= '0;
            rid_q  <= '0;
            addr_q <= '0;
            rem_q  <= '0;
            max_q  <= '0;
        end else if (req_fire) begin
            busy   <= 1'b1;
            tag_q  <= in_tag;
            rid_q  <= in_rid;
            addr_q <= in_addr;
            rem_q  <= len_full;
            max_q  <= in_max_dw;
        end else if (pkt_fire) begin
            rem_q  <= rem_q - pkt_len;
            addr_q <= addr_q + (ADDR_W'(pkt_len) << 2);
            if (rem_q == pkt_len) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rcs_beat_counter.sv
// Module rcs_beat_counter: counts accepted beats inside the current packet
// and flags its first and last beat.
// Assumes pkt_len is non-zero and steady while a packet is in flight.
module rcs_beat_counter #(
    parameter int REM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             beat,
    input  logic [REM_W-1:0] pkt_len,
    output logic             first,
    output logic             last
);
    logic [REM_W-1:0] cnt_q;

    // Decode position within the packet.
    always_comb begin
        first = (cnt_q == '0);
        last  = (cnt_q == pkt_len - 1'b1);
    end

    // Advance per handshake, wrap at packet end, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/read_cpl_splitter.sv
// Module read_cpl_splitter: accepts one read request, then forwards slave
// response data as completion packets no longer than the selected payload
// limit, each with a header sideband (tag, ID, bytes left, low address,
// length). Assumes dword-aligned addresses and in-order slave data.
module read_cpl_splitter #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 8,
    parameter int RID_W  = 16,
    parameter int LEN_W  = 10,
    localparam int REM_W = LEN_W + 1,
    localparam int BC_W  = REM_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mps_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [DATA_W-1:0] cpl_data,
    output logic              cpl_sop,
    output logic              cpl_eop,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [RID_W-1:0]  cpl_rid,
    output logic [BC_W-1:0]   cpl_bytecount,
    output logic [6:0]        cpl_lowaddr,
    output logic [REM_W-1:0]  cpl_len_dw
);
    logic              busy;
    logic              req_fire;
    logic              beat;
    logic              pkt_fire;
    logic [REM_W-1:0]  sel_max_dw;
    logic [REM_W-1:0]  max_q;
    logic [REM_W-1:0]  rem_q;
    logic [REM_W-1:0]  pkt_len;
    logic [ADDR_W-1:0] addr_q;

    rcs_mps_decode #(.REM_W(REM_W)) u_mps (
        .sel    (mps_sel),
        .max_dw (sel_max_dw)
    );

    rcs_req_tracker #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W),
        .RID_W  (RID_W),
        .LEN_W  (LEN_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .in_tag    (req_tag),
        .in_rid    (req_rid),
        .in_addr   (req_addr),
        .in_len    (req_len_dw),
        .in_max_dw (sel_max_dw),
        .pkt_fire  (pkt_fire),
        .pkt_len   (pkt_len),
        .busy      (busy),
        .tag_q     (cpl_tag),
        .rid_q     (cpl_rid),
        .addr_q    (addr_q),
        .rem_q     (rem_q),
        .max_q     (max_q)
    );

    rcs_beat_counter #(.REM_W(REM_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!busy),
        .beat    (beat),
        .pkt_len (pkt_len),
        .first   (cpl_sop),
        .last    (cpl_eop)
    );

    // Handshakes: one request at a time, data gated by an active request.
    always_comb begin
        req_ready = !busy;
        req_fire  = req_valid && req_ready;
        cpl_valid = busy && rd_valid;
        rd_ready  = busy && cpl_ready;
        cpl_data  = rd_data;
        beat      = cpl_valid && cpl_ready;
        pkt_fire  = beat && cpl_eop;
    end

    // Packet sizing and header sideband.
    always_comb begin
        pkt_len       = (rem_q < max_q) ? rem_q : max_q;
        cpl_len_dw    = pkt_len;
        cpl_bytecount = {rem_q, 2'b00};
        cpl_lowaddr   = addr_q[6:0];
    end
endmodule

// File: rtl/rcs_checker.sv
// Module rcs_checker: concurrent properties on the splitter's ports.
// Assumes it is bound to read_cpl_splitter with default widths.
module rcs_checker #(
    parameter int REM_W = 11,
    parameter int BC_W  = 13,
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_ready,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic             cpl_sop,
    input logic             cpl_eop,
    input logic [TAG_W-1:0] cpl_tag,
    input logic [BC_W-1:0]  cpl_bytecount,
    input logic [6:0]       cpl_lowaddr,
    input logic [REM_W-1:0] cpl_len_dw
);
    localparam int MAX_DW = 128;

    logic [BC_W-1:0] len_bytes;
    logic            end_fire;
    logic            final_pkt;

    // Derived views of the port values.
    always_comb begin
        len_bytes = {cpl_len_dw, 2'b00};
        end_fire  = cpl_valid && cpl_ready && cpl_eop;
        final_pkt = (len_bytes == cpl_bytecount);
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cpl_valid && !rd_ready));

    // R8
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> cpl_ready);

    // R4
    len_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_len_dw != '0 && cpl_len_dw <= REM_W'(MAX_DW)
                       && len_bytes <= cpl_bytecount));

    // R11
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> ($stable(cpl_bytecount) && $stable(cpl_lowaddr)
                                       && $stable(cpl_len_dw) && $stable(cpl_tag)));

    // R5
    bc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fire && !final_pkt) |=>
            (cpl_bytecount == $past(cpl_bytecount) - $past(len_bytes) && !req_ready));

    // R6
    la_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fire && !final_pkt) |=>
            (cpl_lowaddr == $past(cpl_lowaddr) + $past(len_bytes[6:0])));

    // R7
    sop_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fire && !final_pkt) |=> cpl_sop);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fire && final_pkt) |=> req_ready);
endmodule

bind read_cpl_splitter rcs_checker #(
    .REM_W (REM_W),
    .BC_W  (BC_W),
    .TAG_W (TAG_W)
) u_rcs_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rd_ready      (rd_ready),
    .cpl_valid     (cpl_valid),
    .cpl_ready     (cpl_ready),
    .cpl_sop       (cpl_sop),
    .cpl_eop       (cpl_eop),
    .cpl_tag       (cpl_tag),
    .cpl_bytecount (cpl_bytecount),
    .cpl_lowaddr   (cpl_lowaddr),
    .cpl_len_dw    (cpl_len_dw)
);

// File: tb/read_cpl_splitter_bench.sv
module read_cpl_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mps_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_rid = '0;
    logic [31:0] req_addr = '0;
    logic [9:0]  req_len_dw = '0;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [31:0] rd_data = '0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [31:0] cpl_data;
    logic        cpl_sop;
    logic        cpl_eop;
    logic [7:0]  cpl_tag;
    logic [15:0] cpl_rid;
    logic [12:0] cpl_bytecount;
    logic [6:0]  cpl_lowaddr;
    logic [10:0] cpl_len_dw;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    read_cpl_splitter u_read_cpl_splitter (
        .clk(clk), .rst_n(rst_n), .mps_sel(mps_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_rid(req_rid), .req_addr(req_addr), .req_len_dw(req_len_dw),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data),
        .cpl_sop(cpl_sop), .cpl_eop(cpl_eop), .cpl_tag(cpl_tag),
        .cpl_rid(cpl_rid), .cpl_bytecount(cpl_bytecount),
        .cpl_lowaddr(cpl_lowaddr), .cpl_len_dw(cpl_len_dw)
    );

    // Vector: [46:45] mps_sel, [44:35] length, [34:3] address,
    // [2:0] mode: b0 throttle cpl_ready, b1 gaps in rd_valid, b2 pokes while busy.
    localparam int NV = 8;
    localparam logic [46:0] VEC [NV] = '{
        {2'd0, 10'd128, 32'h0000_1000, 3'b000},
        {2'd0, 10'd70,  32'h0000_1004, 3'b010},
        {2'd1, 10'd1,   32'h0000_007C, 3'b000},
        {2'd2, 10'd300, 32'h0000_0040, 3'b011},
        {2'd3, 10'd40,  32'h0002_0010, 3'b001},
        {2'd1, 10'd64,  32'h0000_0200, 3'b100},
        {2'd2, 10'd0,   32'h0000_0000, 3'b010},
        {2'd0, 10'd33,  32'h0000_3F8C, 3'b101}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic run_vec(input int idx);
        int  mps, len, mdw, rem, total, bc, k, npk, exp_n, cyc, plen;
        bit  thr, gap, poke;
        logic [31:0] a;
        logic [7:0]  tg;
        mps   = int'(VEC[idx][46:45]);
        len   = int'(VEC[idx][44:35]);
        a     = VEC[idx][34:3];
        thr   = VEC[idx][0];
        gap   = VEC[idx][1];
        poke  = VEC[idx][2];
        mdw   = (mps == 1) ? 64 : (mps == 2) ? 128 : 32;   // R3
        total = (len == 0) ? 1024 : len;                   // R9
        rem   = total;
        exp_n = (total + mdw - 1) / mdw;
        bc = 0; k = 0; npk = 0; cyc = 0;
        tg = 8'h10 + 8'(idx);

        @(negedge clk);
        mps_sel = 2'(mps); req_valid = 1'b1; req_tag = tg;
        req_rid = 16'hA000 + 16'(idx); req_addr = a; req_len_dw = 10'(len);
        rd_valid = 1'b0; cpl_ready = 1'b0;
        #2 chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) mps_sel = 2'(mps) ^ 2'b01;   // R3: late change must not matter
        while (rem > 0 && cyc < 6000) begin
            if (poke && cyc >= 2 && cyc < 6) begin
                req_valid = 1'b1; req_tag = 8'hEE; req_len_dw = 10'd1;
            end else begin
                req_valid = 1'b0;
            end
            rd_valid  = !(gap && (cyc % 4 == 1));
            cpl_ready = !(thr && (cyc % 3 == 2));
            rd_data   = {8'(idx), 24'(k)};
            #2;
            chk(cpl_valid == rd_valid, "R8", "valid follows data", cpl_valid, rd_valid);
            if (poke && cyc == 3)
                chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
            if (cpl_valid && cpl_ready) begin
                plen = (rem < mdw) ? rem : mdw;
                chk(cpl_len_dw == 11'(plen), "R4", "packet length", cpl_len_dw, plen);
                chk(cpl_bytecount == 13'(rem * 4), "R5", "byte count", cpl_bytecount, rem * 4);
                chk(cpl_lowaddr == a[6:0], "R6", "low address", cpl_lowaddr, a[6:0]);
                chk(cpl_sop == (bc == 0), "R7", "sop", cpl_sop, bc == 0);
                chk(cpl_eop == (bc == plen - 1), "R7", "eop", cpl_eop, bc == plen - 1);
                chk(cpl_data == {8'(idx), 24'(k)}, "R8", "data", cpl_data, {8'(idx), 24'(k)});
                chk(cpl_tag == tg && cpl_rid == 16'hA000 + 16'(idx), "R2",
                    "tag held", cpl_tag, tg);
                k++;
                if (bc == plen - 1) begin
                    rem -= plen; a += 32'(plen * 4); bc = 0; npk++;
                end else begin
                    bc++;
                end
            end
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        rd_valid  = 1'b1;
        cpl_ready = 1'b1;
        #2;
        chk(req_ready == 1'b1, "R10", "ready after last beat", req_ready, 1);
        chk(cpl_valid == 1'b0, "R2", "no extra beat after request", cpl_valid, 0);
        chk(npk == exp_n, "R4", "packet count", npk, exp_n);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rd_valid = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(cpl_valid == 1'b0, "R1", "reset cpl_valid", cpl_valid, 0);
        chk(rd_ready == 1'b0, "R1", "reset rd_ready", rd_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(cpl_valid == 1'b0, "R1", "idle with data offered", cpl_valid, 0);
        rd_valid = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(i);

        // Reset in the middle of a packet returns to idle (R1).
        @(negedge clk);
        mps_sel = 2'd0; req_valid = 1'b1; req_tag = 8'h55; req_len_dw = 10'd50;
        req_addr = 32'h100;
        @(negedge clk);
        req_valid = 1'b0; rd_valid = 1'b1; cpl_ready = 1'b1;
        repeat (10) @(negedge clk);
        #2 chk(req_ready == 1'b0, "R2", "busy mid request", req_ready, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(req_ready == 1'b1, "R1", "ready after mid reset", req_ready, 1);
        chk(cpl_valid == 1'b0, "R1", "cpl_valid after mid reset", cpl_valid, 0);
        chk(rd_ready == 1'b0, "R1", "rd_ready after mid reset", rd_ready, 0);

        // Fresh request after reset starts at a packet boundary (R7, R5).
        @(negedge clk);
        req_valid = 1'b1; req_tag = 8'h66; req_len_dw = 10'd2; req_addr = 32'h8;
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        chk(cpl_sop == 1'b1, "R7", "sop after reset", cpl_sop, 1);
        chk(cpl_bytecount == 13'd8, "R5", "byte count after reset", cpl_bytecount, 8);
        chk(cpl_lowaddr == 7'h08, "R6", "low address after reset", cpl_lowaddr, 8);
        repeat (3) @(negedge clk);
        #2 chk(req_ready == 1'b1, "R10", "idle after short request", req_ready, 1);
        rd_valid = 1'b0;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule